// File: doc/BRIEF.md
# Sectioned Clock Register Access Controller

This block sits between a byte-level serial bus slave and the register space of a real-time clock. The bus slave reports framing and byte events as single-cycle strobes: a START, a STOP, an address byte, a written byte and a request for a byte to read. The controller keeps a current address pointer over a 64-byte register space. That space is split into fixed sections: two alarm sections of eight bytes each at 0x00 and 0x08, a four-byte control section at 0x10, an eight-byte time section at 0x30 and a one-byte status register at 0x3F. Sequential accesses stay inside the section where they began. When the pointer runs past the last byte of a section, it returns to the first byte of that section.

Written bytes never reach a register directly. They collect in a staging buffer, and at STOP they are committed as one group, but only when the register write enable (status bit 2) is set. A START before the STOP throws away what was staged. The time section is owned by an external time counter. A commit to it leaves as a strobe with byte data and a byte mask. The alarm and control bytes are stored inside the block, and a commit to them is also announced by a strobe. Every START copies the live time value into a snapshot, so a time read stays consistent while the clock keeps ticking. The status register can be written without the enable, but it allows only one data byte per operation.

Top module: `ccr_access_ctrl`

## Requirements
- R1: After reset the status register reads 0x01 (with `status_flags` low), the two alarm century bytes at 0x07 and 0x0F read 0x20, every other alarm and control byte reads 0x00, and neither commit strobe is high.
- R2: The pointer advances by one per data byte and wraps inside its section (0x37 to 0x30, 0x0F to 0x08, 0x13 to 0x10). After an operation it holds the last address plus one (wrapped), so a following read without an address byte continues from there.
- R3: Written bytes are staged only. No strobe fires and no stored value changes before STOP. At STOP, staged alarm, control or time bytes are committed only if RWEL (status bit 2) is set. Otherwise they are dropped.
- R4: A committed time write raises `time_commit` for exactly one cycle, in the cycle after STOP. It carries byte k of the section in `commit_data[8k+7:8k]` with `commit_mask[k]` set, and it clears RTCF (status bit 0).
- R5: A committed alarm or control write raises `cfg_commit` for one cycle with `commit_base` set to the section's first address. The written bytes can then be read back.
- R6: A status write needs no RWEL and takes effect at STOP. It sets RWEL (bit 2) and WEL (bit 1) from the data. Bits 7..5 read `status_flags[2:0]`, bits 4..3 read 0, and bit 0 reads RTCF.
- R7: In the status register a second data byte in the same operation ends the operation. Later reads return 0x00, later writes are ignored, and the staged status byte is not committed at STOP.
- R8: Each START copies `time_in` into a snapshot. Reads of 0x30..0x37 return snapshot byte (address − 0x30) and ignore later changes of `time_in`.
- R9: A START that arrives before STOP discards the staged bytes. The following STOP commits nothing.
- R10: Addresses outside every section read 0x00 and ignore writes, with no strobe. The pointer still advances by one without wrapping, so 0x2F is followed by 0x30.
- R11: `rd_valid` rises in the cycle after `rd_req`, with the byte in `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_start | input | 1 | START or repeated START seen on the bus |
| bus_stop | input | 1 | STOP seen on the bus |
| addr_valid | input | 1 | Address byte received |
| addr_in | input | 6 | Register address carried by the address byte |
| wr_valid | input | 1 | Data byte written by the master |
| wr_data | input | 8 | Written byte |
| rd_req | input | 1 | Master wants the next byte |
| rd_data | output | 8 | Byte returned for the read |
| rd_valid | output | 1 | `rd_data` is valid |
| time_in | input | 64 | Live time registers, byte k = address 0x30+k |
| status_flags | input | 3 | Read-only status bits 7..5 |
| time_commit | output | 1 | One-cycle strobe: write to the time counter |
| cfg_commit | output | 1 | One-cycle strobe: alarm/control bytes updated |
| commit_base | output | 6 | First address of the committed section |
| commit_data | output | 64 | Committed bytes, byte k at bits 8k+7:8k |
| commit_mask | output | 8 | Which bytes of `commit_data` were written |

## Verification
On every cycle the assertions check the following. A commit strobe only follows a STOP, and a non-status commit only follows a STOP with RWEL set. A strobe always carries a non-empty mask. The two strobes never coincide, a time strobe lasts a single cycle, and every read request is answered in the next cycle. The bench scenarios are needed for the data itself: how the pointer wraps in each section, continuing after an operation, the frozen snapshot, termination in the status register, discarding staged bytes on a repeated START, and the reset contents, because each of these depends on what was written or read several operations earlier.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int CCR_AW      = 6;
  localparam int CCR_DW      = 8;
  localparam int SEC_MAX     = 8;                    // widest section in bytes
  localparam int OFF_W       = $clog2(SEC_MAX);
  localparam int ALM_BYTES   = 8;
  localparam int CTRL_BYTES  = 4;
  localparam int CFG_BYTES   = 2 * ALM_BYTES + CTRL_BYTES;
  localparam logic [CCR_AW-1:0] ALM0_BASE = 6'h00;
  localparam logic [CCR_AW-1:0] ALM1_BASE = 6'h08;
  localparam logic [CCR_AW-1:0] CTRL_BASE = 6'h10;
  localparam logic [CCR_AW-1:0] TIME_BASE = 6'h30;
  localparam logic [CCR_AW-1:0] STAT_ADDR = 6'h3F;
  localparam logic [CCR_DW-1:0] CENTURY_RST = 8'h20;

  typedef enum logic [2:0] {
    SEC_NONE, SEC_ALM0, SEC_ALM1, SEC_CTRL, SEC_TIME, SEC_STAT
  } ccr_sec_e;

  function automatic ccr_sec_e sec_of(input logic [CCR_AW-1:0] a);
    if (a < ALM1_BASE)                                  return SEC_ALM0;
    else if (a < CTRL_BASE)                             return SEC_ALM1;
    else if (a < CTRL_BASE + CCR_AW'(CTRL_BYTES))       return SEC_CTRL;
    else if (a >= TIME_BASE && a < TIME_BASE + CCR_AW'(SEC_MAX)) return SEC_TIME;
    else if (a == STAT_ADDR)                            return SEC_STAT;
    else                                                return SEC_NONE;
  endfunction

  // next pointer value: wrap inside the section, plain increment elsewhere
  function automatic logic [CCR_AW-1:0] next_ptr(input logic [CCR_AW-1:0] a);
    logic [CCR_AW-1:0] n;
    case (sec_of(a))
      SEC_ALM0, SEC_ALM1, SEC_TIME: n = {a[CCR_AW-1:3], a[2:0] + 3'd1};
      SEC_CTRL:                     n = {a[CCR_AW-1:2], a[1:0] + 2'd1};
      SEC_STAT:                     n = a;
      default:                      n = a + 1'b1;
    endcase
    return n;
  endfunction

  function automatic ccr_sec_e cfg_idx_sec(input int i);
    if (i < ALM_BYTES)          return SEC_ALM0;
    else if (i < 2 * ALM_BYTES) return SEC_ALM1;
    else                        return SEC_CTRL;
  endfunction

  function automatic logic [CCR_AW-1:0] sec_base(input ccr_sec_e s);
    case (s)
      SEC_ALM1: return ALM1_BASE;
      SEC_CTRL: return CTRL_BASE;
      SEC_TIME: return TIME_BASE;
      SEC_STAT: return STAT_ADDR;
      default:  return ALM0_BASE;
    endcase
  endfunction
endpackage

// File: rtl/ccr_pointer.sv
module ccr_pointer
  import ccr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_start,
  input  logic              addr_valid,
  input  logic [CCR_AW-1:0] addr_in,
  input  logic              step,
  output logic [CCR_AW-1:0] ptr,
  output ccr_sec_e          sec,
  output logic              accept,
  output logic              term
);
  logic stat_used;

  assign sec    = sec_of(ptr);
  assign accept = step && !term && !(sec == SEC_STAT && stat_used);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr       <= '0;
      stat_used <= 1'b0;
      term      <= 1'b0;
    end else if (bus_start) begin
      stat_used <= 1'b0;
      term      <= 1'b0;
    end else if (addr_valid) begin
      ptr       <= addr_in;
      stat_used <= 1'b0;
      term      <= 1'b0;
    end else if (step && !term) begin
      if (sec == SEC_STAT && stat_used) begin
        term <= 1'b1;
      end else begin
        ptr <= next_ptr(ptr);
        if (sec == SEC_STAT) stat_used <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ccr_stage.sv
module ccr_stage
  import ccr_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clear,
  input  logic                      wr_valid,
  input  logic                      accept,
  input  logic [CCR_AW-1:0]         ptr,
  input  ccr_sec_e                  sec,
  input  logic [CCR_DW-1:0]         wr_data,
  output logic [SEC_MAX*CCR_DW-1:0] stage_data,
  output logic [SEC_MAX-1:0]        stage_mask,
  output ccr_sec_e                  stage_sec
);
  logic [CCR_DW-1:0] buf_q [SEC_MAX];
  logic [OFF_W-1:0]  off;

  assign off = ptr[OFF_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_mask <= '0;
      stage_sec  <= SEC_NONE;
      for (int i = 0; i < SEC_MAX; i++) buf_q[i] <= '0;
    end else if (clear) begin
      stage_mask <= '0;
    end else if (wr_valid && accept && sec != SEC_NONE) begin
      buf_q[off]      <= wr_data;
      stage_mask[off] <= 1'b1;
      stage_sec       <= sec;
    end
  end

  for (genvar g = 0; g < SEC_MAX; g++) begin : g_flat
    assign stage_data[g*CCR_DW +: CCR_DW] = buf_q[g];
  end
endmodule

// File: rtl/ccr_regs.sv
module ccr_regs
  import ccr_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bus_start,
  input  logic                      bus_stop,
  input  logic                      rd_req,
  input  logic                      accept,
  input  logic                      term,
  input  logic [CCR_AW-1:0]         ptr,
  input  ccr_sec_e                  sec,
  input  logic [SEC_MAX*CCR_DW-1:0] time_in,
  input  logic [2:0]                status_flags,
  input  logic [SEC_MAX*CCR_DW-1:0] stage_data,
  input  logic [SEC_MAX-1:0]        stage_mask,
  input  ccr_sec_e                  stage_sec,
  output logic [CCR_DW-1:0]         rd_data,
  output logic                      rd_valid,
  output logic                      time_commit,
  output logic                      cfg_commit,
  output logic [CCR_AW-1:0]         commit_base,
  output logic [SEC_MAX*CCR_DW-1:0] commit_data,
  output logic [SEC_MAX-1:0]        commit_mask,
  output logic                      rwel
);
  localparam int STAT_OFF = SEC_MAX - 1;

  logic [CCR_DW-1:0]         cfg_q [CFG_BYTES];
  logic [SEC_MAX*CCR_DW-1:0] snap_q;
  logic                      wel, rtcf;
  logic                      fire;
  logic [CCR_DW-1:0]         rd_mux;
  logic [CCR_DW-1:0]         stat_byte;

  assign fire      = bus_stop && (stage_mask != '0) && !term;
  assign stat_byte = stage_data[STAT_OFF*CCR_DW +: CCR_DW];

  always_comb begin
    case (sec)
      SEC_ALM0, SEC_ALM1, SEC_CTRL: rd_mux = cfg_q[ptr[4:0]];
      SEC_TIME: rd_mux = snap_q[ptr[OFF_W-1:0]*CCR_DW +: CCR_DW];
      SEC_STAT: rd_mux = {status_flags, 2'b00, rwel, wel, rtcf};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data     <= '0;
      rd_valid    <= 1'b0;
      time_commit <= 1'b0;
      cfg_commit  <= 1'b0;
      commit_base <= '0;
      commit_data <= '0;
      commit_mask <= '0;
      snap_q      <= '0;
      rwel        <= 1'b0;
      wel         <= 1'b0;
      rtcf        <= 1'b1;
      for (int i = 0; i < CFG_BYTES; i++)
        cfg_q[i] <= ((i % ALM_BYTES) == ALM_BYTES - 1 && i < 2 * ALM_BYTES)
                    ? CENTURY_RST : '0;
    end else begin
      rd_valid    <= rd_req;
      time_commit <= 1'b0;
      cfg_commit  <= 1'b0;
      if (rd_req) rd_data <= accept ? rd_mux : '0;
      if (bus_start) snap_q <= time_in;
      if (fire) begin
        commit_base <= sec_base(stage_sec);
        commit_data <= stage_data;
        commit_mask <= stage_mask;
        if (stage_sec == SEC_STAT) begin
          rwel <= stat_byte[2];
          wel  <= stat_byte[1];
        end else if (rwel) begin
          if (stage_sec == SEC_TIME) begin
            time_commit <= 1'b1;
            rtcf        <= 1'b0;
          end else begin
            cfg_commit <= 1'b1;
            for (int i = 0; i < CFG_BYTES; i++)
              if (cfg_idx_sec(i) == stage_sec && stage_mask[i % SEC_MAX])
                cfg_q[i] <= stage_data[(i % SEC_MAX)*CCR_DW +: CCR_DW];
          end
        end
      end
    end
  end
endmodule

// File: rtl/ccr_access_ctrl.sv
module ccr_access_ctrl
  import ccr_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bus_start,
  input  logic                      bus_stop,
  input  logic                      addr_valid,
  input  logic [CCR_AW-1:0]         addr_in,
  input  logic                      wr_valid,
  input  logic [CCR_DW-1:0]         wr_data,
  input  logic                      rd_req,
  output logic [CCR_DW-1:0]         rd_data,
  output logic                      rd_valid,
  input  logic [SEC_MAX*CCR_DW-1:0] time_in,
  input  logic [2:0]                status_flags,
  output logic                      time_commit,
  output logic                      cfg_commit,
  output logic [CCR_AW-1:0]         commit_base,
  output logic [SEC_MAX*CCR_DW-1:0] commit_data,
  output logic [SEC_MAX-1:0]        commit_mask
);
  logic [CCR_AW-1:0]         ptr;
  ccr_sec_e                  sec, stage_sec;
  logic                      accept, term, rwel;
  logic [SEC_MAX*CCR_DW-1:0] stage_data;
  logic [SEC_MAX-1:0]        stage_mask;

  ccr_pointer u_ptr (
    .clk, .rst, .bus_start, .addr_valid, .addr_in,
    .step(wr_valid | rd_req), .ptr, .sec, .accept, .term
  );

  ccr_stage u_stage (
    .clk, .rst, .clear(bus_start | addr_valid | bus_stop),
    .wr_valid, .accept, .ptr, .sec, .wr_data,
    .stage_data, .stage_mask, .stage_sec
  );

  ccr_regs u_regs (
    .clk, .rst, .bus_start, .bus_stop, .rd_req, .accept, .term, .ptr, .sec,
    .time_in, .status_flags, .stage_data, .stage_mask, .stage_sec,
    .rd_data, .rd_valid, .time_commit, .cfg_commit, .commit_base,
    .commit_data, .commit_mask, .rwel
  );
endmodule

// File: rtl/ccr_access_ctrl_chk.sv
module ccr_access_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_stop,
  input logic       rd_req,
  input logic       rd_valid,
  input logic       time_commit,
  input logic       cfg_commit,
  input logic       rwel,
  input logic [7:0] commit_mask
);
  a_r3_commit_after_stop: assert property (@(posedge clk) disable iff (rst)
    (time_commit || cfg_commit) |-> $past(bus_stop));

  a_r3_commit_needs_rwel: assert property (@(posedge clk) disable iff (rst)
    (time_commit || cfg_commit) |-> $past(rwel));

  a_r4_time_single_pulse: assert property (@(posedge clk) disable iff (rst)
    time_commit |=> !time_commit);

  a_r4_mask_nonempty: assert property (@(posedge clk) disable iff (rst)
    (time_commit || cfg_commit) |-> commit_mask != 8'h00);

  a_r5_one_target: assert property (@(posedge clk) disable iff (rst)
    !(time_commit && cfg_commit));

  a_r11_read_answered: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid);

  a_r11_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_req));
endmodule

bind ccr_access_ctrl ccr_access_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .bus_stop(bus_stop), .rd_req(rd_req),
  .rd_valid(rd_valid), .time_commit(time_commit), .cfg_commit(cfg_commit),
  .rwel(rwel), .commit_mask(commit_mask)
);

// File: tb/tb_ccr_access_ctrl.sv
module tb_ccr_access_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_start = 0, bus_stop = 0, addr_valid = 0, wr_valid = 0, rd_req = 0;
  logic [5:0]  addr_in = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic [63:0] time_in = 64'h0807_0605_0403_0201;
  logic [2:0]  status_flags = 3'b000;
  logic        time_commit, cfg_commit;
  logic [5:0]  commit_base;
  logic [63:0] commit_data;
  logic [7:0]  commit_mask;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ccr_access_ctrl dut (.*);

  // {address, expected byte} read after reset (R1, R8 for time bytes)
  localparam logic [13:0] RST_VEC [0:8] = '{
    {6'h3F, 8'h01}, {6'h07, 8'h20}, {6'h0F, 8'h20}, {6'h00, 8'h00},
    {6'h10, 8'h00}, {6'h13, 8'h00}, {6'h20, 8'h00}, {6'h30, 8'h01},
    {6'h37, 8'h08}};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic t_start();
    @(negedge clk) bus_start = 1; @(negedge clk) bus_start = 0;
  endtask
  task automatic t_addr(input logic [5:0] a);
    @(negedge clk) begin addr_valid = 1; addr_in = a; end
    @(negedge clk) addr_valid = 0;
  endtask
  task automatic t_wr(input logic [7:0] d);
    @(negedge clk) begin wr_valid = 1; wr_data = d; end
    @(negedge clk) wr_valid = 0;
  endtask
  task automatic t_rd(output logic [7:0] d);
    @(negedge clk) rd_req = 1;
    @(negedge clk) rd_req = 0;
    d = rd_data;
    chk("R11 rd_valid", rd_valid, 1'b1);
  endtask
  task automatic t_stop(output logic tc, output logic cc);
    @(negedge clk) bus_stop = 1;
    @(negedge clk) bus_stop = 0;
    tc = time_commit; cc = cfg_commit;
  endtask
  task automatic rand_read(input logic [5:0] a, output logic [7:0] d);
    logic tc, cc;
    t_start(); t_addr(a); t_start(); t_rd(d); t_stop(tc, cc);
  endtask
  task automatic write1(input logic [5:0] a, input logic [7:0] d,
                        output logic tc, output logic cc);
    t_start(); t_addr(a); t_wr(d); t_stop(tc, cc);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic tc, cc;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 no strobe after reset", {time_commit, cfg_commit}, 2'b00);

    // R1 reset contents walked from the vector table
    for (int i = 0; i < 9; i++) begin
      rand_read(RST_VEC[i][13:8], d);
      chk($sformatf("R1 reset read %h", RST_VEC[i][13:8]), d, RST_VEC[i][7:0]);
    end

    // R3: time write without RWEL is dropped
    write1(6'h30, 8'h11, tc, cc);
    chk("R3 no commit without RWEL", tc, 1'b0);

    // R6: status write without RWEL, bits 2 and 1
    write1(6'h3F, 8'h06, tc, cc);
    chk("R6 status write no strobe", {tc, cc}, 2'b00);
    rand_read(6'h3F, d);
    chk("R6 status readback", d, 8'h07);

    // R3/R4: time write with wrap 0x37 -> 0x30
    t_start(); t_addr(6'h37); t_wr(8'hAA); t_wr(8'hBB);
    chk("R3 nothing before STOP", time_commit, 1'b0);
    t_stop(tc, cc);
    chk("R4 time_commit after STOP", {tc, cc}, 2'b10);
    chk("R4 commit_mask", commit_mask, 8'h81);
    chk("R4 byte7", commit_data[63:56], 8'hAA);
    chk("R4 byte0 after wrap", commit_data[7:0], 8'hBB);
    @(negedge clk);
    chk("R4 single-cycle pulse", time_commit, 1'b0);
    rand_read(6'h3F, d);
    chk("R4 RTCF cleared", d, 8'h06);

    // R5/R2: alarm write with wrap 0x0F -> 0x08
    t_start(); t_addr(6'h0E); t_wr(8'h12); t_wr(8'h34); t_wr(8'h56); t_stop(tc, cc);
    chk("R5 cfg_commit", {tc, cc}, 2'b01);
    chk("R5 commit_base", commit_base, 6'h08);
    chk("R5 commit_mask", commit_mask, 8'hC1);
    t_start(); t_addr(6'h0E); t_rd(d);
    chk("R5 read 0x0E", d, 8'h12);
    t_rd(d);
    chk("R5 read 0x0F", d, 8'h34);
    t_stop(tc, cc);
    t_start(); t_rd(d); t_stop(tc, cc);
    chk("R2 current-address read wraps to 0x08", d, 8'h56);

    // R2: control section wraps 0x13 -> 0x10
    t_start(); t_addr(6'h13); t_wr(8'h77); t_wr(8'h88); t_stop(tc, cc);
    chk("R2 control commit", commit_base, 6'h10);
    t_start(); t_addr(6'h13); t_start(); t_rd(d);
    chk("R2 ctrl 0x13", d, 8'h77);
    t_rd(d);
    chk("R2 ctrl wrap 0x10", d, 8'h88);
    t_stop(tc, cc);

    // R8: snapshot frozen at START
    time_in = 64'h1122_3344_5566_7788;
    t_start(); t_addr(6'h30); t_start();
    time_in = 64'hFFFF_FFFF_FFFF_FFFF;
    t_rd(d);
    chk("R8 snapshot byte0", d, 8'h88);
    t_rd(d);
    chk("R8 snapshot byte1", d, 8'h77);
    t_stop(tc, cc);

    // R7: second status byte ends the operation
    t_start(); t_addr(6'h3F); t_wr(8'h00); t_wr(8'h00); t_stop(tc, cc);
    rand_read(6'h3F, d);
    chk("R7 terminated write not committed", d, 8'h06);
    t_start(); t_addr(6'h3F); t_start(); t_rd(d);
    chk("R7 first status read", d, 8'h06);
    t_rd(d);
    chk("R7 second read returns 0", d, 8'h00);
    t_stop(tc, cc);

    // R9: repeated START discards staged bytes
    t_start(); t_addr(6'h31); t_wr(8'h99); t_start(); t_stop(tc, cc);
    chk("R9 aborted write no commit", {tc, cc}, 2'b00);

    // R10: undefined address
    time_in = 64'h0000_0000_0000_00C3;
    write1(6'h20, 8'h55, tc, cc);
    chk("R10 undefined write no strobe", {tc, cc}, 2'b00);
    t_start(); t_addr(6'h2F); t_start(); t_rd(d);
    chk("R10 undefined read 0", d, 8'h00);
    t_rd(d);
    chk("R10 pointer 0x2F -> 0x30", d, 8'hC3);
    t_stop(tc, cc);

    // R6: read-only flags
    status_flags = 3'b101;
    rand_read(6'h3F, d);
    chk("R6 flags in bits 7..5", d, 8'hA6);

    // R3: clear RWEL, alarm write dropped
    write1(6'h3F, 8'h00, tc, cc);
    write1(6'h00, 8'hEE, tc, cc);
    chk("R3 alarm write without RWEL", {tc, cc}, 2'b00);
    rand_read(6'h00, d);
    chk("R3 alarm byte unchanged", d, 8'h00);

    @(negedge clk);
    chk("R11 rd_valid idle", rd_valid, 1'b0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule